// File: doc/BRIEF.md
# Dual Byte Queue with Direct Storage Port

This block holds two byte-wide circular queues in one flat storage of 256 bytes. The transmit queue lives in the lower half and the receive queue in the upper half. The host fills the transmit queue and the radio side drains it. The radio side fills the receive queue and the host drains it. Each queue has a write pointer and a read pointer, and all four pointers are brought out so they can be read for debug.

A second host path reads and writes any byte of the storage by an 8-bit address without moving a pointer. Tools use it to inspect or patch queue contents in place. The receive queue has a one-byte bypass stage. A byte that arrives while the receive queue is empty waits there instead of in storage, so the direct path cannot see it. Only a normal host pop delivers it.

Top module: `dual_byte_queue`

## Requirements
- R1: Storage addresses 0x00..0x7F hold the transmit queue and 0x80..0xFF hold the receive queue. A queued byte sits at its half's base plus bits 6:0 of the write pointer in effect when it was stored.
- R2: A direct write or a direct read changes none of the four pointers. A direct write is visible to later direct reads and to the queue head at that location.
- R3: A host push appends to the transmit queue and a radio pop removes its oldest byte. A radio push appends to the receive queue and a host pop removes its oldest byte. Both queues keep first-in first-out order, and each queue's head byte shows on its data output before the pop.
- R4: Each pointer is 8 bits: bits 6:0 index the half and bit 7 is a wrap bit. Every accepted store or removal advances its pointer by one. A queue is empty when its pointers are equal, and full when the indices match and the wrap bits differ.
- R5: A radio push into a fully empty receive queue goes to the bypass stage and leaves the receive write pointer unchanged. A direct read of storage does not return that byte, and the next host pop returns it. The receive queue therefore holds up to 129 bytes.
- R6: A push into a full queue or a pop from an empty queue is dropped and leaves the pointers unchanged. It sets that queue's sticky overflow or underflow flag, which stays set.
- R7: A flush of one queue returns its pointers to zero and clears its flags (and, for receive, the bypass stage). The other queue is left as it was.
- R8: When the radio side and the host both act on the same queue in one cycle, the radio operation is carried out. The host operation is dropped and sets no flag.
- R9: After reset all pointers are zero, both queues are empty and not full, and all flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_push | input | 1 | Host stores host_wdata into the transmit queue |
| host_wdata | input | 8 | Byte for host_push |
| host_pop | input | 1 | Host removes the receive queue head |
| host_rdata | output | 8 | Receive queue head byte |
| dir_we | input | 1 | Direct write of dir_wdata at dir_addr |
| dir_addr | input | 8 | Direct access address |
| dir_wdata | input | 8 | Direct write byte |
| dir_rdata | output | 8 | Storage byte at dir_addr |
| rad_tx_pop | input | 1 | Radio removes the transmit queue head |
| rad_tx_data | output | 8 | Transmit queue head byte |
| rad_rx_push | input | 1 | Radio stores rad_rx_data into the receive queue |
| rad_rx_data | input | 8 | Byte for rad_rx_push |
| flush_tx | input | 1 | Flush the transmit queue |
| flush_rx | input | 1 | Flush the receive queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty, bypass stage included |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |
| tx_wptr | output | 8 | Transmit write pointer |
| tx_rptr | output | 8 | Transmit read pointer |
| rx_wptr | output | 8 | Receive write pointer |
| rx_rptr | output | 8 | Receive read pointer |

## Verification
The checks assume that the host never raises a direct write in the same cycle as a host push or host pop. One property states this so that a violation is reported instead of silently breaking the pointer-stability check. Each bench task drives one kind of operation at a time and sets host and direct strobes in separate cycles. The radio strobes are asserted together with a host strobe only in the priority scenario, which is the one case where the host operation is meant to be dropped.

// File: rtl/dfq_pkg.sv
package dfq_pkg;
  localparam int unsigned BYTE_W = 8;
  // storage write ports, lowest priority first
  localparam int unsigned WP_DIRECT = 0;
  localparam int unsigned WP_TXPUSH = 1;
  localparam int unsigned WP_RXPUSH = 2;
  localparam int unsigned N_WR      = 3;
  // storage read ports
  localparam int unsigned RP_DIRECT = 0;
  localparam int unsigned RP_RXHEAD = 1;
  localparam int unsigned RP_TXHEAD = 2;
  localparam int unsigned N_RD      = 3;
endpackage

// File: rtl/dfq_mem.sv
module dfq_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NWR    = 3,
  parameter int unsigned NRD    = 3
) (
  input  logic                           clk,
  input  logic [NWR-1:0]                 we,
  input  logic [NWR-1:0][ADDR_W-1:0]     waddr,
  input  logic [NWR-1:0][DATA_W-1:0]     wdata,
  input  logic [NRD-1:0][ADDR_W-1:0]     raddr,
  output logic [NRD-1:0][DATA_W-1:0]     rdata
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] store [WORDS];

  // higher port index is written last and wins on an address clash
  always_ff @(posedge clk) begin
    for (int p = 0; p < NWR; p++) begin
      if (we[p]) store[waddr[p]] <= wdata[p];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = store[raddr[r]];
  end
endmodule

// File: rtl/dfq_ptr.sv
module dfq_ptr #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W:0]   wptr,
  output logic [IDX_W:0]   rptr,
  output logic             full,
  output logic             empty,
  output logic             wr_ok,
  output logic             ovf,
  output logic             udf
);
  localparam int unsigned PTR_W = IDX_W + 1;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [PTR_W-1:0] wptr_nxt, rptr_nxt;
  logic             ovf_nxt, udf_nxt, rd_ok;

  assign empty = (wptr == rptr);
  assign full  = (wptr[IDX_W] != rptr[IDX_W]) &&
                 (wptr[IDX_W-1:0] == rptr[IDX_W-1:0]);
  assign wr_ok = push & ~full & ~flush;
  assign rd_ok = pop & ~empty & ~flush;

  always_comb begin
    wptr_nxt = wptr;
    rptr_nxt = rptr;
    ovf_nxt  = ovf | (push & full);
    udf_nxt  = udf | (pop & empty);
    if (flush) begin
      wptr_nxt = '0;
      rptr_nxt = '0;
      ovf_nxt  = 1'b0;
      udf_nxt  = 1'b0;
    end else begin
      if (wr_ok) wptr_nxt = wptr + PTR_W'(1);
      if (rd_ok) rptr_nxt = rptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      ovf  <= 1'b0;
      udf  <= 1'b0;
    end else begin
      wptr <= wptr_nxt;
      rptr <= rptr_nxt;
      ovf  <= ovf_nxt;
      udf  <= udf_nxt;
    end
  end

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !flush |=> ovf);
  p_udf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    udf && !flush |=> udf);
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> $stable(wptr) && ovf);
  p_empty_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && empty && !push && !flush |=> $stable(rptr) && udf);
  p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wptr == '0) && (rptr == '0) && !ovf && !udf);
  p_occupancy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(wptr - rptr) <= PTR_W'(DEPTH));
endmodule

// File: rtl/dual_byte_queue.sv
module dual_byte_queue #(
  parameter int unsigned DATA_W  = dfq_pkg::BYTE_W,
  parameter int unsigned HALF_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_push,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_pop,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              dir_we,
  input  logic [HALF_AW:0]  dir_addr,
  input  logic [DATA_W-1:0] dir_wdata,
  output logic [DATA_W-1:0] dir_rdata,
  input  logic              rad_tx_pop,
  output logic [DATA_W-1:0] rad_tx_data,
  input  logic              rad_rx_push,
  input  logic [DATA_W-1:0] rad_rx_data,
  input  logic              flush_tx,
  input  logic              flush_rx,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              tx_ovf,
  output logic              tx_udf,
  output logic              rx_ovf,
  output logic              rx_udf,
  output logic [HALF_AW:0]  tx_wptr,
  output logic [HALF_AW:0]  tx_rptr,
  output logic [HALF_AW:0]  rx_wptr,
  output logic [HALF_AW:0]  rx_rptr
);
  import dfq_pkg::*;

  localparam int unsigned ADDR_W = HALF_AW + 1;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // radio side wins over host on the same queue
  logic tx_push_req, rx_pop_req;
  assign tx_push_req = host_push & ~rad_tx_pop;
  assign rx_pop_req  = host_pop  & ~rad_rx_push;

  // receive bypass stage
  logic              rxm_empty, rxm_full, rxm_push, rxm_pop, rx_wr_ok, tx_wr_ok;
  logic              byp_vld, byp_vld_nxt, byp_load, byp_take;
  logic [DATA_W-1:0] byp_q;

  assign byp_load = rad_rx_push & ~byp_vld & rxm_empty & ~flush_rx;
  assign byp_take = rx_pop_req & byp_vld & ~flush_rx;
  assign rxm_push = rad_rx_push & ~byp_load;
  assign rxm_pop  = rx_pop_req & ~byp_vld;

  always_comb begin
    byp_vld_nxt = byp_vld;
    if (flush_rx)      byp_vld_nxt = 1'b0;
    else if (byp_load) byp_vld_nxt = 1'b1;
    else if (byp_take) byp_vld_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) byp_vld <= 1'b0;
    else          byp_vld <= byp_vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (byp_load) byp_q <= rad_rx_data;
  end

  dfq_ptr #(.IDX_W(HALF_AW)) u_tx_ptr (
    .clk(clk), .rst_n(rst_q_n), .flush(flush_tx),
    .push(tx_push_req), .pop(rad_tx_pop),
    .wptr(tx_wptr), .rptr(tx_rptr), .full(tx_full), .empty(tx_empty),
    .wr_ok(tx_wr_ok), .ovf(tx_ovf), .udf(tx_udf)
  );

  dfq_ptr #(.IDX_W(HALF_AW)) u_rx_ptr (
    .clk(clk), .rst_n(rst_q_n), .flush(flush_rx),
    .push(rxm_push), .pop(rxm_pop),
    .wptr(rx_wptr), .rptr(rx_rptr), .full(rxm_full), .empty(rxm_empty),
    .wr_ok(rx_wr_ok), .ovf(rx_ovf), .udf(rx_udf)
  );

  assign rx_full  = rxm_full;
  assign rx_empty = rxm_empty & ~byp_vld;

  // shared storage: lower half transmit, upper half receive
  logic [N_WR-1:0]                 m_we;
  logic [N_WR-1:0][ADDR_W-1:0]     m_waddr;
  logic [N_WR-1:0][DATA_W-1:0]     m_wdata;
  logic [N_RD-1:0][ADDR_W-1:0]     m_raddr;
  logic [N_RD-1:0][DATA_W-1:0]     m_rdata;

  always_comb begin
    m_we[WP_DIRECT]    = dir_we;
    m_waddr[WP_DIRECT] = dir_addr;
    m_wdata[WP_DIRECT] = dir_wdata;
    m_we[WP_TXPUSH]    = tx_wr_ok;
    m_waddr[WP_TXPUSH] = {1'b0, tx_wptr[HALF_AW-1:0]};
    m_wdata[WP_TXPUSH] = host_wdata;
    m_we[WP_RXPUSH]    = rx_wr_ok;
    m_waddr[WP_RXPUSH] = {1'b1, rx_wptr[HALF_AW-1:0]};
    m_wdata[WP_RXPUSH] = rad_rx_data;
    m_raddr[RP_DIRECT] = dir_addr;
    m_raddr[RP_RXHEAD] = {1'b1, rx_rptr[HALF_AW-1:0]};
    m_raddr[RP_TXHEAD] = {1'b0, tx_rptr[HALF_AW-1:0]};
  end

  dfq_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NWR(N_WR), .NRD(N_RD)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .raddr(m_raddr), .rdata(m_rdata)
  );

  assign dir_rdata   = m_rdata[RP_DIRECT];
  assign rad_tx_data = m_rdata[RP_TXHEAD];
  assign host_rdata  = byp_vld ? byp_q : m_rdata[RP_RXHEAD];

  // input rule: direct writes and host queue strobes are never combined (R2)
  p_no_mix_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(dir_we && (host_push || host_pop)));
  p_direct_keeps_ptr_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    dir_we && !rad_tx_pop && !rad_rx_push && !flush_tx && !flush_rx |=>
      $stable(tx_wptr) && $stable(tx_rptr) && $stable(rx_wptr) && $stable(rx_rptr));
  p_bypass_hold_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    rad_rx_push && rx_empty && !flush_rx |=> !rx_empty && $stable(rx_wptr));
  p_prio_tx_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    rad_tx_pop && host_push && !flush_tx |=> $stable(tx_wptr) && (tx_ovf == $past(tx_ovf)));
  p_prio_rx_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    rad_rx_push && host_pop && !flush_rx |=> $stable(rx_rptr) && (rx_udf == $past(rx_udf)));
endmodule

// File: tb/test_dual_byte_queue.sv
`timescale 1ns/1ps
module test_dual_byte_queue;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_push, host_pop, dir_we, rad_tx_pop, rad_rx_push, flush_tx, flush_rx;
  logic [7:0] host_wdata, dir_addr, dir_wdata, rad_rx_data;
  logic [7:0] host_rdata, dir_rdata, rad_tx_data;
  logic       tx_full, tx_empty, rx_full, rx_empty, tx_ovf, tx_udf, rx_ovf, rx_udf;
  logic [7:0] tx_wptr, tx_rptr, rx_wptr, rx_rptr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dual_byte_queue i_dual_byte_queue (
    .clk(clk), .rst_n(rst_n),
    .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
    .dir_we(dir_we), .dir_addr(dir_addr), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
    .rad_tx_pop(rad_tx_pop), .rad_tx_data(rad_tx_data),
    .rad_rx_push(rad_rx_push), .rad_rx_data(rad_rx_data),
    .flush_tx(flush_tx), .flush_rx(flush_rx),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_ovf(tx_ovf), .tx_udf(tx_udf), .rx_ovf(rx_ovf), .rx_udf(rx_udf),
    .tx_wptr(tx_wptr), .tx_rptr(tx_rptr), .rx_wptr(rx_wptr), .rx_rptr(rx_rptr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    host_push = 0; host_pop = 0; dir_we = 0; rad_tx_pop = 0; rad_rx_push = 0;
    flush_tx = 0; flush_rx = 0; host_wdata = 0; dir_addr = 0; dir_wdata = 0; rad_rx_data = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic push_tx(input logic [7:0] d);
    host_push = 1; host_wdata = d; tick();
  endtask
  task automatic pop_tx();
    rad_tx_pop = 1; tick();
  endtask
  task automatic push_rx(input logic [7:0] d);
    rad_rx_push = 1; rad_rx_data = d; tick();
  endtask
  task automatic pop_rx();
    host_pop = 1; tick();
  endtask
  task automatic dwrite(input logic [7:0] a, input logic [7:0] d);
    dir_we = 1; dir_addr = a; dir_wdata = d; tick();
  endtask
  task automatic flush_both();
    flush_tx = 1; flush_rx = 1; tick();
  endtask

  task automatic t_reset();
    chk("R9", "tx_wptr", tx_wptr, 0);
    chk("R9", "rx_rptr", rx_rptr, 0);
    chk("R9", "empties", {tx_empty, rx_empty}, 2'b11);
    chk("R9", "fulls", {tx_full, rx_full}, 0);
    chk("R9", "flags", {tx_ovf, tx_udf, rx_ovf, rx_udf}, 0);
  endtask

  task automatic t_map_direct();
    push_tx(8'h11);
    dir_addr = 8'h00; #0.1;
    chk("R1", "tx byte at 0x00", dir_rdata, 8'h11);
    chk("R4", "tx_wptr after push", tx_wptr, 1);
    dwrite(8'h05, 8'h3C);
    dwrite(8'h85, 8'hC7);
    chk("R2", "pointers after direct writes", {tx_wptr, tx_rptr, rx_wptr, rx_rptr}, 32'h0100_0000);
    dir_addr = 8'h05; #0.1;
    chk("R2", "readback 0x05", dir_rdata, 8'h3C);
    dir_addr = 8'h85; #0.1;
    chk("R2", "readback 0x85", dir_rdata, 8'hC7);
    chk("R2", "pointers after direct reads", {tx_wptr, tx_rptr, rx_wptr, rx_rptr}, 32'h0100_0000);
    dwrite(8'h00, 8'h99);
    chk("R2", "tx head patched", rad_tx_data, 8'h99);
    chk("R2", "tx_rptr kept", tx_rptr, 0);
  endtask

  task automatic t_order();
    logic [7:0] got [3];
    flush_both();
    push_tx(8'hA0); push_tx(8'hA1); push_tx(8'hA2);
    for (int i = 0; i < 3; i++) begin got[i] = rad_tx_data; pop_tx(); end
    chk("R3", "tx order", {got[0], got[1], got[2]}, 24'hA0A1A2);
    chk("R3", "tx empty after drain", tx_empty, 1);
    push_rx(8'hB0); push_rx(8'hB1); push_rx(8'hB2);
    dir_addr = 8'h80; #0.1;
    chk("R1", "rx byte at 0x80", dir_rdata, 8'hB1);
    dir_addr = 8'h81; #0.1;
    chk("R1", "rx byte at 0x81", dir_rdata, 8'hB2);
    for (int i = 0; i < 3; i++) begin got[i] = host_rdata; pop_rx(); end
    chk("R3", "rx order", {got[0], got[1], got[2]}, 24'hB0B1B2);
    chk("R4", "rx pointers", {rx_wptr, rx_rptr}, 16'h0202);
  endtask

  task automatic t_bypass();
    logic [7:0] got;
    flush_rx = 1; tick();
    dwrite(8'h80, 8'h00);
    push_rx(8'hA5);
    chk("R5", "rx not empty", rx_empty, 0);
    chk("R5", "rx_wptr unchanged", rx_wptr, 0);
    dir_addr = 8'h80; #0.1;
    chk("R5", "bypass byte hidden", dir_rdata, 8'h00);
    got = host_rdata;
    pop_rx();
    chk("R5", "pop returns bypass byte", got, 8'hA5);
    chk("R5", "rx empty after pop", rx_empty, 1);
  endtask

  task automatic t_tx_full();
    int bad = 0;
    flush_tx = 1; tick();
    for (int i = 0; i < 128; i++) push_tx(8'(i));
    chk("R4", "tx full", {tx_full, tx_wptr}, 9'h180);
    push_tx(8'hFF);
    chk("R6", "overflow dropped", {tx_ovf, tx_wptr}, 9'h180);
    for (int i = 0; i < 128; i++) begin
      if (rad_tx_data !== 8'(i)) bad++;
      pop_tx();
    end
    chk("R3", "tx data mismatches over full drain", bad, 0);
    chk("R4", "tx empty after wrap", {tx_empty, tx_rptr}, 9'h180);
    pop_tx();
    chk("R6", "underflow dropped", {tx_udf, tx_rptr}, 9'h180);
    tick();
    chk("R6", "flags sticky", {tx_ovf, tx_udf}, 2'b11);
  endtask

  task automatic t_rx_full();
    flush_rx = 1; tick();
    for (int i = 0; i < 128; i++) push_rx(8'(i + 8'h10));
    chk("R5", "rx not full at 128", {rx_full, rx_wptr}, 9'h07F);
    push_rx(8'hEE);
    chk("R5", "rx full at 129", {rx_full, rx_wptr}, 9'h180);
    push_rx(8'hEF);
    chk("R6", "rx overflow", {rx_ovf, rx_wptr}, 9'h180);
    chk("R3", "rx head oldest", host_rdata, 8'h10);
  endtask

  task automatic t_flush();
    flush_tx = 1; tick();
    chk("R7", "tx cleared", {tx_wptr, tx_rptr, 6'b0, tx_ovf, tx_udf}, 24'h0);
    chk("R7", "rx untouched", {rx_ovf, rx_wptr}, 9'h180);
    flush_rx = 1; tick();
    chk("R7", "rx cleared", {rx_empty, rx_ovf, rx_wptr}, 10'h200);
  endtask

  task automatic t_prio();
    push_tx(8'h42);
    host_push = 1; host_wdata = 8'h55; rad_tx_pop = 1; tick();
    chk("R8", "tx host push dropped", {tx_wptr, tx_rptr}, 16'h0101);
    chk("R8", "tx no flag", {tx_empty, tx_ovf}, 2'b10);
    rad_rx_push = 1; rad_rx_data = 8'h66; host_pop = 1; tick();
    chk("R8", "rx host pop dropped", {rx_empty, rx_udf}, 2'b00);
    chk("R8", "rx byte kept", host_rdata, 8'h66);
    pop_rx();
    chk("R8", "rx drained", {rx_empty, rx_udf}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_map_direct();
    t_order();
    t_bypass();
    t_tx_full();
    t_rx_full();
    t_flush();
    t_prio();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule